// File: doc/BRIEF.md
# Posted-Write Overflow Interval Timer

This block is a 32-bit up-counting interval timer with two clocks. The register interface runs on a bus clock. The counter runs on an independent functional clock. Software programs a timeout of N ticks by loading the counter with all-ones minus N and then setting the start bit. When the count passes all-ones it wraps, and the wrap raises an overflow flag. In one-shot mode the counter lands on zero and halts. In auto-reload mode it restarts from the load register, which gives a periodic event.

Writes to the control, counter and load registers are posted. Each one is carried into the functional domain by its own toggle handshake. A per-register pending bit stays set until the functional domain has applied the value and the acknowledgment has come back to the bus domain. While that bit is set, a further write to the same register is dropped, so software polls the bit before it writes again. The overflow event returns to the bus domain as a status flag. Software clears the flag by writing a one to it. Two separate masks derive an interrupt output and a wakeup output from the flag.

A self-clearing soft reset is also carried through a handshake. It returns every register to zero. Counter reads return a synchronized snapshot that is refreshed continuously.

Top module: `posted_interval_timer`

## Requirements
- R1: After the reset input is released, the revision word (address 0) reads 0x4D21_0103 (upper half nonzero). Every other register reads zero, and irq_out and wake_out are low.
- R2: Addresses: 1 config, 2 status, 3 irq enable, 4 wake enable, 5 pending, 6 control, 7 counter, 8 load. A write to control, counter or load sets its pending bit (bit 0 control, bit 1 counter, bit 2 load) on the next bus cycle. The bit clears by itself later, and control and load then read back the written value.
- R3: A write to control, counter or load while that register's pending bit is set is dropped, and the earlier value stays in force.
- R4: While control bit 0 (start) is set, the counter advances by one on every functional clock. Once a cleared start bit has crossed over, the counter holds its value. Counter reads return a synchronized snapshot.
- R5: One-shot (control bit 1 clear): a counter preset to 0xFFFFFFFF-N reaches the wrap after N+1 ticks. The wrap sets status bit 1. The counter then becomes 0 and stops.
- R6: Auto-reload (control bit 1 set): each wrap loads the counter from the load register. With load 0xFFFFFFFF-P, overflows repeat every P+1 functional ticks.
- R7: Writing status with bit 1 set clears the overflow flag. Writing status with bit 1 clear leaves the flag unchanged.
- R8: irq_out equals status bit 1 AND irq-enable bit 1. wake_out equals status bit 1 AND wake-enable bit 1. The two masks act independently.
- R9: Writing config with bit 0 set starts a soft reset. Config bit 0 reads 1 until the reset completes (4 functional cycles of reset plus the handshake) and then reads 0. All registers, pending bits and the status flag are then zero, and the counter sits at zero and is stopped.
- R10: Every register write issued while the soft reset is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| fclk | input | 1 | Functional (counting) clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Write strobe, sampled on bclk |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Masked overflow interrupt |
| wake_out | output | 1 | Masked overflow wakeup |

## Verification
The assertions check on every functional cycle how the counter steps: it increments while running, holds while stopped, stops at zero after a one-shot wrap, reloads on an auto-reload wrap and is cleared during the soft-reset window. On the bus side they check that the handshake delivers a single apply pulse per posted write, that held data stays stable while a write is pending, and that the soft reset leaves no pending bit behind. Only the bench scenarios can show the timing seen from software across the two clocks. These scenarios are the N+1 tick timeout, the P+1 tick reload period, the dropping of writes to a pending register, the write-one-to-clear flag and its masks, and the busy window of the soft reset.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_AW = 4;

  // word addresses
  localparam logic [TMR_AW-1:0] A_REV  = 4'd0;
  localparam logic [TMR_AW-1:0] A_CFG  = 4'd1;
  localparam logic [TMR_AW-1:0] A_STAT = 4'd2;
  localparam logic [TMR_AW-1:0] A_IEN  = 4'd3;
  localparam logic [TMR_AW-1:0] A_WEN  = 4'd4;
  localparam logic [TMR_AW-1:0] A_PEND = 4'd5;
  localparam logic [TMR_AW-1:0] A_CTRL = 4'd6;
  localparam logic [TMR_AW-1:0] A_CNT  = 4'd7;
  localparam logic [TMR_AW-1:0] A_LOAD = 4'd8;

  // posted channels; index equals the pending-register bit for the first three
  localparam int CH_CTRL = 0;
  localparam int CH_CNT  = 1;
  localparam int CH_LOAD = 2;
  localparam int CH_RST  = 3;
  localparam int NCH     = 4;

  // control and flag bit positions
  localparam int C_START = 0;
  localparam int C_AUTO  = 1;
  localparam int S_OVF   = 1;
  localparam int CFG_SRST = 0;
endpackage

// File: rtl/tmr_xing.sv
// One posted-write channel: bus-side hold register plus toggle handshake.
module tmr_xing #(
  parameter int W      = 32,
  parameter int SYNC_N = 2
) (
  input  logic         bclk,
  input  logic         fclk,
  input  logic         rst_n,
  input  logic         b_wr,
  input  logic [W-1:0] b_data,
  output logic         b_pend,
  output logic         f_apply,
  output logic [W-1:0] f_data,
  input  logic         f_ready
);
  logic              req_t;
  logic [W-1:0]      hold;
  logic [SYNC_N-1:0] ack_sync;
  logic [SYNC_N-1:0] req_sync;
  logic              req_seen;
  logic              ack_f;
  logic              wr_go;

  assign b_pend  = req_t ^ ack_sync[SYNC_N-1];
  assign wr_go   = b_wr && !b_pend;
  assign f_apply = req_sync[SYNC_N-1] ^ req_seen;
  assign f_data  = hold;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      req_t    <= 1'b0;
      hold     <= '0;
      ack_sync <= '0;
    end else begin
      ack_sync <= {ack_sync[SYNC_N-2:0], ack_f};
      if (wr_go) begin
        req_t <= ~req_t;
        hold  <= b_data;
      end
    end
  end

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      req_sync <= '0;
      req_seen <= 1'b0;
      ack_f    <= 1'b0;
    end else begin
      req_sync <= {req_sync[SYNC_N-2:0], req_t};
      req_seen <= req_sync[SYNC_N-1];
      if (f_ready) ack_f <= req_seen;
    end
  end

  // R3: a write arriving while pending leaves held value and request untouched
  assert_drop_pending_R3: assert property (@(posedge bclk) disable iff (!rst_n)
    (b_pend && b_wr) |=> ($stable(hold) && $stable(req_t)));

  // R2: each posted write produces exactly one apply pulse
  assert_single_apply_R2: assert property (@(posedge fclk) disable iff (!rst_n)
    f_apply |=> !f_apply);
endmodule

// File: rtl/tmr_snap.sv
// Continuous counter snapshot from the functional domain to the bus domain.
module tmr_snap #(
  parameter int W      = 32,
  parameter int SYNC_N = 2
) (
  input  logic         bclk,
  input  logic         fclk,
  input  logic         rst_n,
  input  logic [W-1:0] f_val,
  output logic [W-1:0] b_val
);
  logic              s_tog;
  logic [W-1:0]      snap;
  logic [SYNC_N-1:0] ack_sync;
  logic [SYNC_N-1:0] tog_sync;
  logic              seen;
  logic              b_take;

  assign b_take = tog_sync[SYNC_N-1] ^ seen;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      s_tog    <= 1'b0;
      snap     <= '0;
      ack_sync <= '0;
    end else begin
      ack_sync <= {ack_sync[SYNC_N-2:0], seen};
      if (ack_sync[SYNC_N-1] == s_tog) begin
        snap  <= f_val;
        s_tog <= ~s_tog;
      end
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      tog_sync <= '0;
      seen     <= 1'b0;
      b_val    <= '0;
    end else begin
      tog_sync <= {tog_sync[SYNC_N-2:0], s_tog};
      if (b_take) begin
        b_val <= snap;
        seen  <= tog_sync[SYNC_N-1];
      end
    end
  end

  // R4: the bus-side copy only moves when a new snapshot has arrived
  assert_snap_stable_R4: assert property (@(posedge bclk) disable iff (!rst_n)
    !b_take |=> $stable(b_val));
endmodule

// File: rtl/tmr_core.sv
// Functional-domain counter, control copy and soft-reset window.
module tmr_core
  import tmr_pkg::*;
#(
  parameter int DW      = 32,
  parameter int RST_CYC = 4
) (
  input  logic                     fclk,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           ap,
  input  logic [NCH-1:0][DW-1:0]   fd,
  output logic [DW-1:0]            cnt,
  output logic                     ovf_tog,
  output logic                     ready,
  output logic                     run,
  output logic                     auto_rl,
  output logic                     ovf_evt
);
  localparam int HW = $clog2(RST_CYC + 1);

  function automatic logic is_wrap(input logic [DW-1:0] v);
    return v == {DW{1'b1}};
  endfunction

  function automatic logic [DW-1:0] next_count(input logic [DW-1:0] v,
                                               input logic rl,
                                               input logic [DW-1:0] ldv);
    if (is_wrap(v)) return rl ? ldv : '0;
    return v + 1'b1;
  endfunction

  logic [DW-1:0] cnt_q, load_q;
  logic [1:0]    ctl_q;
  logic [HW-1:0] hold_q;
  logic          tog_q;
  logic          quiet;

  assign cnt     = cnt_q;
  assign ovf_tog = tog_q;
  assign run     = ctl_q[C_START];
  assign auto_rl = ctl_q[C_AUTO];
  assign ready   = (hold_q == '0);
  assign ovf_evt = run && is_wrap(cnt_q) && ready && !ap[CH_RST] && !ap[CH_CNT];
  assign quiet   = ready && (ap == '0);

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
      ctl_q  <= '0;
      hold_q <= '0;
      tog_q  <= 1'b0;
    end else if (ap[CH_RST]) begin
      hold_q <= HW'(RST_CYC - 1);
      cnt_q  <= '0;
      load_q <= '0;
      ctl_q  <= '0;
    end else if (!ready) begin
      hold_q <= hold_q - 1'b1;
      cnt_q  <= '0;
      load_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (ap[CH_LOAD]) load_q <= fd[CH_LOAD];
      if (ap[CH_CNT])  cnt_q <= fd[CH_CNT];
      else if (run)    cnt_q <= next_count(cnt_q, auto_rl, load_q);
      if (ovf_evt)     tog_q <= ~tog_q;
      if (ap[CH_CTRL]) ctl_q <= fd[CH_CTRL][1:0];
      else if (ovf_evt && !auto_rl) ctl_q[C_START] <= 1'b0;
    end
  end

  assert_count_step_R4: assert property (@(posedge fclk) disable iff (!rst_n)
    (quiet && run && !is_wrap(cnt_q)) |=> (cnt_q == DW'($past(cnt_q) + 1'b1)));

  assert_hold_stopped_R4: assert property (@(posedge fclk) disable iff (!rst_n)
    (quiet && !run) |=> $stable(cnt_q));

  assert_oneshot_stop_R5: assert property (@(posedge fclk) disable iff (!rst_n)
    (quiet && ovf_evt && !auto_rl) |=> (cnt_q == '0 && !run));

  assert_reload_R6: assert property (@(posedge fclk) disable iff (!rst_n)
    (quiet && ovf_evt && auto_rl) |=> (cnt_q == $past(load_q) && run));

  assert_srst_window_R9: assert property (@(posedge fclk) disable iff (!rst_n)
    ap[CH_RST] |=> (cnt_q == '0 && !run && !ready));
endmodule

// File: rtl/posted_interval_timer.sv
module posted_interval_timer
  import tmr_pkg::*;
#(
  parameter int          DW      = 32,
  parameter int          SYNC_N  = 2,
  parameter int          RST_CYC = 4,
  parameter logic [31:0] REV_ID  = 32'h4D21_0103
) (
  input  logic              bclk,
  input  logic              fclk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [TMR_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_out,
  output logic              wake_out
);
  logic [NCH-1:0]         ch_wr, ch_pend, ch_ap;
  logic [NCH-1:0][DW-1:0] ch_bd, ch_fd;
  logic                   busy, bus_ok, srst_go;
  logic                   ien_q, wen_q, st_q;
  logic [1:0]             ctrl_sh;
  logic [DW-1:0]          load_sh, cnt_snap, f_cnt;
  logic                   f_ovf_tog, f_ready, f_run, f_auto, f_ovf_evt;
  logic [SYNC_N-1:0]      ovf_sync;
  logic                   ovf_seen, ovf_edge;

  assign busy     = ch_pend[CH_RST];
  assign bus_ok   = bus_wr && !busy;
  assign srst_go  = ch_wr[CH_RST] && !busy;
  assign ovf_edge = ovf_sync[SYNC_N-1] ^ ovf_seen;

  assign ch_wr[CH_CTRL] = bus_ok && (bus_addr == A_CTRL);
  assign ch_wr[CH_CNT]  = bus_ok && (bus_addr == A_CNT);
  assign ch_wr[CH_LOAD] = bus_ok && (bus_addr == A_LOAD);
  assign ch_wr[CH_RST]  = bus_wr && (bus_addr == A_CFG) && bus_wdata[CFG_SRST];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_bd[i] = bus_wdata;
    tmr_xing #(.W(DW), .SYNC_N(SYNC_N)) u_x (
      .bclk   (bclk),
      .fclk   (fclk),
      .rst_n  (rst_n),
      .b_wr   (ch_wr[i]),
      .b_data (ch_bd[i]),
      .b_pend (ch_pend[i]),
      .f_apply(ch_ap[i]),
      .f_data (ch_fd[i]),
      .f_ready((i == CH_RST) ? f_ready : 1'b1)
    );
  end

  tmr_core #(.DW(DW), .RST_CYC(RST_CYC)) u_core (
    .fclk   (fclk),
    .rst_n  (rst_n),
    .ap     (ch_ap),
    .fd     (ch_fd),
    .cnt    (f_cnt),
    .ovf_tog(f_ovf_tog),
    .ready  (f_ready),
    .run    (f_run),
    .auto_rl(f_auto),
    .ovf_evt(f_ovf_evt)
  );

  tmr_snap #(.W(DW), .SYNC_N(SYNC_N)) u_snap (
    .bclk (bclk),
    .fclk (fclk),
    .rst_n(rst_n),
    .f_val(f_cnt),
    .b_val(cnt_snap)
  );

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_sync <= '0;
      ovf_seen <= 1'b0;
    end else begin
      ovf_sync <= {ovf_sync[SYNC_N-2:0], f_ovf_tog};
      ovf_seen <= ovf_sync[SYNC_N-1];
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q   <= 1'b0;
      wen_q   <= 1'b0;
      st_q    <= 1'b0;
      ctrl_sh <= '0;
      load_sh <= '0;
    end else if (srst_go) begin
      ien_q   <= 1'b0;
      wen_q   <= 1'b0;
      st_q    <= 1'b0;
      ctrl_sh <= '0;
      load_sh <= '0;
    end else begin
      if (bus_ok && bus_addr == A_IEN) ien_q <= bus_wdata[S_OVF];
      if (bus_ok && bus_addr == A_WEN) wen_q <= bus_wdata[S_OVF];
      if (ch_wr[CH_CTRL] && !ch_pend[CH_CTRL]) ctrl_sh <= bus_wdata[1:0];
      if (ch_wr[CH_LOAD] && !ch_pend[CH_LOAD]) load_sh <= bus_wdata;
      if (ovf_edge && !busy) st_q <= 1'b1;
      else if (bus_ok && bus_addr == A_STAT && bus_wdata[S_OVF]) st_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_REV:  bus_rdata = DW'(REV_ID);
      A_CFG:  bus_rdata[CFG_SRST] = busy;
      A_STAT: bus_rdata[S_OVF] = st_q;
      A_IEN:  bus_rdata[S_OVF] = ien_q;
      A_WEN:  bus_rdata[S_OVF] = wen_q;
      A_PEND: bus_rdata[2:0] = ch_pend[2:0];
      A_CTRL: bus_rdata[1:0] = ctrl_sh;
      A_CNT:  bus_rdata = cnt_snap;
      A_LOAD: bus_rdata = load_sh;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_out  = st_q && ien_q;
  assign wake_out = st_q && wen_q;

  // R9: when the soft reset reports done, no data write is still in flight
  assert_srst_clean_R9: assert property (@(posedge bclk) disable iff (!rst_n)
    $fell(busy) |-> (ch_pend[2:0] == 3'b000));

  // R9: starting a soft reset clears the bus-side state on the next cycle
  assert_srst_clear_R9: assert property (@(posedge bclk) disable iff (!rst_n)
    srst_go |=> (!st_q && !ien_q && !wen_q && ctrl_sh == 2'b00 && load_sh == '0));

  // R10: while the reset is in progress the enables cannot be changed
  assert_busy_ignore_R10: assert property (@(posedge bclk) disable iff (!rst_n)
    ($past(busy) && busy) |-> ($stable(ien_q) && $stable(wen_q)));
endmodule

// File: tb/sim_posted_interval_timer.sv
`timescale 1ns/1ps
module sim_posted_interval_timer;
  localparam logic [3:0] AR_REV = 4'd0, AR_CFG = 4'd1, AR_STAT = 4'd2, AR_IEN = 4'd3,
                         AR_WEN = 4'd4, AR_PEND = 4'd5, AR_CTRL = 4'd6, AR_CNT = 4'd7,
                         AR_LOAD = 4'd8;
  localparam logic [31:0] EXP_REV = 32'h4D21_0103;

  logic        bclk = 1'b0, fclk = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, wake_out;

  int checks = 0, errors = 0;
  int fcount = 0;
  bit done = 1'b0;

  always #10 bclk = ~bclk;      // 50 MHz
  always #6.5 fclk = ~fclk;
  always @(posedge fclk) fcount <= fcount + 1;

  posted_interval_timer u0 (
    .bclk(bclk), .fclk(fclk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out), .wake_out(wake_out)
  );

  function automatic logic [31:0] preload(input int unsigned n);
    return 32'hFFFF_FFFF - n;
  endfunction
  function automatic int wrap_ticks(input int n);
    return n + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge bclk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bclk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge bclk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bclk);
  endtask

  task automatic wait_pend_clear(input string req);
    logic [31:0] p;
    p = 32'hFFFF_FFFF;
    for (int k = 0; k < 200 && p[2:0] != 3'b000; k++) rd(AR_PEND, p);
    chk(p[2:0] == 3'b000, req, p, 32'h0);
  endtask

  task automatic wait_flag(output int ts, output bit seen);
    logic [31:0] s;
    seen = 1'b0; ts = 0;
    for (int k = 0; k < 2000 && !seen; k++) begin
      rd(AR_STAT, s);
      if (s[1]) begin seen = 1'b1; ts = fcount; end
    end
  endtask

  initial begin
    logic [31:0] v, c1, c2;
    int t0, t1, n, p;
    int ts[4];
    bit seen;
    void'($urandom(32'd2718));
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(AR_REV, v);  chk(v == EXP_REV, "R1 rev", v, EXP_REV);
    for (int a = 1; a <= 8; a++) begin
      rd(4'(a), v); chk(v == 32'h0, "R1 reg zero", v, 32'h0);
    end
    chk({30'd0, irq_out, wake_out} == 32'h0, "R1 outputs", {30'd0, irq_out, wake_out}, 32'h0);

    // R2 / R3 posted write and drop while pending
    wr(AR_LOAD, 32'h0000_1234);
    rd(AR_PEND, v); chk(v[2:0] == 3'b100, "R2 load pending", v, 32'h4);
    wr(AR_LOAD, 32'h0000_9999);
    wait_pend_clear("R2 pend clears");
    rd(AR_LOAD, v); chk(v == 32'h0000_1234, "R3 dropped write", v, 32'h1234);

    for (int i = 0; i < 5; i++) begin
      logic [31:0] r;
      r = $urandom;
      wr(AR_LOAD, r);
      wait_pend_clear("R2 pend clears rnd");
      rd(AR_LOAD, v); chk(v == r, "R2 load readback", v, r);
    end
    wr(AR_CTRL, 32'h2);
    rd(AR_PEND, v); chk(v[0] == 1'b1, "R2 ctrl pending", v, 32'h1);
    wait_pend_clear("R2 ctrl clears");
    rd(AR_CTRL, v); chk(v == 32'h2, "R2 ctrl readback", v, 32'h2);

    // R4 counting and stopping
    wr(AR_CNT, 32'd100); wait_pend_clear("R4 setup");
    wr(AR_CTRL, 32'h1);  wait_pend_clear("R4 setup");
    idle(30);
    rd(AR_CNT, c1); idle(10); rd(AR_CNT, c2);
    chk((c2 > c1) && (c2 - c1 >= 5) && (c2 - c1 <= 30), "R4 advancing", c2 - c1, 32'd15);
    wr(AR_CTRL, 32'h0); wait_pend_clear("R4 stop");
    idle(30);
    rd(AR_CNT, c1); idle(10); rd(AR_CNT, c2);
    chk(c1 == c2, "R4 holds when stopped", c2, c1);

    // R5 one-shot timeout, random lengths
    for (int i = 0; i < 3; i++) begin
      n = (i == 0) ? 3 : int'($urandom_range(150, 20));
      wr(AR_STAT, 32'h2);
      wr(AR_CNT, preload(n)); wait_pend_clear("R5 setup");
      rd(AR_STAT, v); chk(v[1] == 1'b0, "R5 flag clear before start", v, 32'h0);
      wr(AR_CTRL, 32'h1);
      t0 = fcount;
      wait_flag(t1, seen);
      chk(seen && (t1 - t0 >= wrap_ticks(n)) && (t1 - t0 <= wrap_ticks(n) + 16),
          "R5 timeout length", t1 - t0, wrap_ticks(n));
      idle(20);
      rd(AR_CNT, c1); idle(10); rd(AR_CNT, c2);
      chk(c1 == 32'h0 && c2 == 32'h0, "R5 stops at zero", c2, 32'h0);
    end

    // R6 auto-reload period
    p = 80;
    wr(AR_CTRL, 32'h0); wait_pend_clear("R6 setup");
    wr(AR_LOAD, preload(p)); wait_pend_clear("R6 setup");
    wr(AR_CNT, preload(p));  wait_pend_clear("R6 setup");
    wr(AR_STAT, 32'h2);
    wr(AR_CTRL, 32'h3);
    for (int k = 0; k < 4; k++) begin
      wait_flag(ts[k], seen);
      chk(seen, "R6 overflow repeats", 32'(seen), 32'h1);
      wr(AR_STAT, 32'h2);
    end
    for (int k = 1; k < 4; k++) begin
      int d;
      d = ts[k] - ts[k-1] - wrap_ticks(p);
      chk(d >= -5 && d <= 5, "R6 period", ts[k] - ts[k-1], wrap_ticks(p));
    end
    wr(AR_CTRL, 32'h0); wait_pend_clear("R6 stop");

    // R7 / R8 flag clear semantics and masks
    wr(AR_STAT, 32'h2);
    wr(AR_CNT, preload(5)); wait_pend_clear("R7 setup");
    wr(AR_CTRL, 32'h1);
    wait_flag(t1, seen);
    wr(AR_STAT, 32'h0);
    rd(AR_STAT, v); chk(v == 32'h2, "R7 zero write keeps flag", v, 32'h2);
    for (int i = 0; i < 4; i++) begin
      wr(AR_IEN, (i & 1) ? 32'h2 : 32'h0);
      wr(AR_WEN, (i & 2) ? 32'h2 : 32'h0);
      idle(1);
      chk(irq_out == ((i & 1) != 0) && wake_out == ((i & 2) != 0), "R8 masks",
          {30'd0, irq_out, wake_out}, 32'(((i & 1) << 1) | ((i >> 1) & 1)));
    end
    wr(AR_STAT, 32'h2);
    rd(AR_STAT, v); chk(v == 32'h0, "R7 one clears flag", v, 32'h0);
    chk(!irq_out && !wake_out, "R8 outputs drop", {30'd0, irq_out, wake_out}, 32'h0);

    // R9 / R10 soft reset
    wr(AR_LOAD, 32'h55); wait_pend_clear("R9 setup");
    wr(AR_CNT, 32'h10);  wait_pend_clear("R9 setup");
    wr(AR_CTRL, 32'h3);  wait_pend_clear("R9 setup");
    wr(AR_IEN, 32'h2);
    wr(AR_CFG, 32'h1);
    rd(AR_CFG, v); chk(v == 32'h1, "R9 busy reads 1", v, 32'h1);
    wr(AR_WEN, 32'h2);
    wr(AR_LOAD, 32'h77);
    v = 32'h1;
    for (int k = 0; k < 200 && v[0]; k++) rd(AR_CFG, v);
    chk(v == 32'h0, "R9 self-clears", v, 32'h0);
    rd(AR_WEN, v);  chk(v == 32'h0, "R10 wen write ignored", v, 32'h0);
    rd(AR_LOAD, v); chk(v == 32'h0, "R10 load write ignored", v, 32'h0);
    rd(AR_IEN, v);  chk(v == 32'h0, "R9 ien zero", v, 32'h0);
    rd(AR_CTRL, v); chk(v == 32'h0, "R9 ctrl zero", v, 32'h0);
    rd(AR_PEND, v); chk(v == 32'h0, "R9 pend zero", v, 32'h0);
    rd(AR_STAT, v); chk(v == 32'h0, "R9 status zero", v, 32'h0);
    idle(30);
    rd(AR_CNT, c1); idle(10); rd(AR_CNT, c2);
    chk(c1 == 32'h0 && c2 == 32'h0, "R9 counter zero and stopped", c2, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge bclk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule